// File: doc/BRIEF.md
# Serial EEPROM Port Arbiter

This block lets software reach a serial EEPROM, driven bit by bit, through a memory port that other requesters also use. Software writes an 8-bit control register. Setting the port-request bit asks for the memory port. While the port reports busy, the request waits. Once the port is free, the arbiter takes it and raises the ready bit at once. From then on, the stored select, clock and data-out bits drive the EEPROM pins, and the EEPROM's data output can be read back in bit 0.

While access is held, every later write to the register clears ready. Ready then comes back after a fixed delay of about 800 ns. Software uses this as a pacing timer between edges of the serial clock. The delay is a cycle count, worked out from the clock frequency parameter.

Writing the register with the port-request bit clear releases the port. Release forces the pins low and clears ready. The EEPROM command protocol belongs to software and is not part of this block.

Top module: `eeprom_port_arbiter`

## Requirements
- R1: After reset the EEPROM pins and ext_req_o are low, and rd_data[6:0] reads 0.
- R2: Writing bit 5 = 1 requests the port. The grant happens only on a clock edge where port_busy_i is low. While port_busy_i stays high, the block stays ungranted and bit 4 (ready) reads 0. Bit 5 reads back the held request.
- R3: The grant takes effect on the first edge after the request write where port_busy_i is low. Ready (bit 4) reads 1 right after that edge, with no added delay.
- R4: While granted, the stored bits drive the pins: bit 3 drives ee_cs_o, bit 2 drives ee_sk_o and bit 1 drives ee_do_o. Bit 0 reads ee_di_i.
- R5: While not granted, ee_cs_o, ee_sk_o and ee_do_o are low whatever bits 3..1 hold, and bit 0 reads 0.
- R6: A write with bit 5 = 1 while granted clears ready on the write edge. Ready reads 1 again exactly DELAY_CYC edges after the write edge, where DELAY_CYC = ceil(DELAY_NS*CLK_MHZ/1000), which is 80 with the default parameters.
- R7: A write made while the delay is still running restarts the full DELAY_CYC delay from the new write edge.
- R8: A write with bit 5 = 0 releases the port on its edge: the pins go low and ready reads 0. Access comes back only after a new request and a free port.
- R9: Bit 6 is stored, drives ext_req_o and reads back. Bit 7 reads ext_ack_i. Writes to bits 7, 4 and 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| port_busy_i | input | 1 | Memory port busy with another requester |
| ext_ack_i | input | 1 | External arbitration acknowledge |
| ext_req_o | output | 1 | External arbitration request |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_do_o | output | 1 | Data to the EEPROM |
| ee_di_i | input | 1 | Data from the EEPROM |

## Verification
Register fields and pins change on the write edge itself. The grant and the first rise of ready come one edge after the request write, when the port is free. The delayed rise of ready comes exactly DELAY_CYC edges after the write edge. The bench drives inputs on the falling edge and counts falling edges after each write. It checks that ready is still low one edge before it is due and high on the edge it is due. Bit 0 and bit 7 are combinational, so they are sampled a short step after their input changes.

// File: rtl/eeprom_arb_pkg.sv
package eeprom_arb_pkg;

    // Bit positions of the control register (software decodes these)
    localparam int unsigned B_XACK = 7;
    localparam int unsigned B_XREQ = 6;
    localparam int unsigned B_PREQ = 5;
    localparam int unsigned B_RDY  = 4;
    localparam int unsigned B_SEL  = 3;
    localparam int unsigned B_SCLK = 2;
    localparam int unsigned B_SDO  = 1;
    localparam int unsigned B_SDI  = 0;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_OWN  = 2'd2
    } arb_state_t;

    typedef struct packed {
        logic xreq;
        logic sel;
        logic sclk;
        logic sdo;
    } ctrl_t;

    function automatic int unsigned delay_cycles(input int unsigned ns, input int unsigned mhz);
        int unsigned c;
        c = (ns * mhz + 999) / 1000;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic logic [7:0] pack_status(
        input logic  xack,
        input ctrl_t c,
        input logic  preq,
        input logic  rdy,
        input logic  sdi
    );
        logic [7:0] v;
        v         = '0;
        v[B_XACK] = xack;
        v[B_XREQ] = c.xreq;
        v[B_PREQ] = preq;
        v[B_RDY]  = rdy;
        v[B_SEL]  = c.sel;
        v[B_SCLK] = c.sclk;
        v[B_SDO]  = c.sdo;
        v[B_SDI]  = sdi;
        return v;
    endfunction

endpackage

// File: rtl/eeprom_ctrl_regs.sv
module eeprom_ctrl_regs
    import eeprom_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output ctrl_t      ctrl_o
);
    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q.xreq <= wr_data[B_XREQ];
            ctrl_q.sel  <= wr_data[B_SEL];
            ctrl_q.sclk <= wr_data[B_SCLK];
            ctrl_q.sdo  <= wr_data[B_SDO];
        end
    end

    assign ctrl_o = ctrl_q;
endmodule

// File: rtl/eeprom_port_grant.sv
module eeprom_port_grant
    import eeprom_arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_wr_i,
    input  logic rel_wr_i,
    input  logic port_busy_i,
    output logic grant_now_o,
    output logic granted_o,
    output logic held_o
);
    arb_state_t state_q, state_d;

    always_comb begin
        state_d     = state_q;
        grant_now_o = 1'b0;
        unique case (state_q)
            ST_IDLE: if (req_wr_i) state_d = ST_WAIT;
            ST_WAIT: begin
                if (rel_wr_i) begin
                    state_d = ST_IDLE;
                end else if (!port_busy_i) begin
                    state_d     = ST_OWN;
                    grant_now_o = 1'b1;
                end
            end
            ST_OWN:  if (rel_wr_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign granted_o = (state_q == ST_OWN);
    assign held_o    = (state_q != ST_IDLE);

    // R2: ownership is only taken on an edge where the port was free
    assert_grant_when_free_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(granted_o) |-> $past(!port_busy_i));

    // R8: a release write always leaves the port unowned
    assert_release_drops_R8: assert property (@(posedge clk) disable iff (rst)
        rel_wr_i |=> !granted_o);
endmodule

// File: rtl/eeprom_ready_timer.sv
module eeprom_ready_timer #(
    parameter int unsigned DELAY_CYC = 80,
    localparam int unsigned CNT_W    = $clog2(DELAY_CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic grant_now_i,
    input  logic restart_i,
    input  logic release_i,
    output logic rdy_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             rdy_q;

    localparam logic [CNT_W-1:0] LOAD = CNT_W'(DELAY_CYC);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst || release_i) begin
            cnt_q <= '0;
            rdy_q <= 1'b0;
        end else if (grant_now_i) begin
            cnt_q <= '0;
            rdy_q <= 1'b1;
        end else if (restart_i) begin
            cnt_q <= LOAD;
            rdy_q <= 1'b0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
            if (cnt_q == ONE) rdy_q <= 1'b1;
        end
    end

    assign rdy_o = rdy_q;

    // R6: a write while granted forces ready low on the next cycle
    assert_restart_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (restart_i && !release_i) |=> !rdy_o);

    // R3/R6: ready rises only on a grant or when the delay expires
    assert_rise_source_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy_o) |-> ($past(grant_now_i) || $past(cnt_q) == ONE));

    // R7: the count never exceeds the loaded delay
    assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LOAD);
endmodule

// File: rtl/eeprom_pin_gate.sv
module eeprom_pin_gate
    import eeprom_arb_pkg::*;
(
    input  logic       granted_i,
    input  logic       held_i,
    input  logic       rdy_i,
    input  ctrl_t      ctrl_i,
    input  logic       ext_ack_i,
    input  logic       ee_di_i,
    output logic       ee_cs_o,
    output logic       ee_sk_o,
    output logic       ee_do_o,
    output logic       ext_req_o,
    output logic [7:0] rd_data
);
    always_comb begin
        ee_cs_o   = granted_i & ctrl_i.sel;
        ee_sk_o   = granted_i & ctrl_i.sclk;
        ee_do_o   = granted_i & ctrl_i.sdo;
        ext_req_o = ctrl_i.xreq;
        rd_data   = pack_status(ext_ack_i, ctrl_i, held_i, rdy_i & granted_i,
                                granted_i & ee_di_i);
    end
endmodule

// File: rtl/eeprom_port_arbiter.sv
module eeprom_port_arbiter
    import eeprom_arb_pkg::*;
#(
    parameter int unsigned CLK_MHZ  = 100,
    parameter int unsigned DELAY_NS = 800,
    localparam int unsigned DELAY_CYC = delay_cycles(DELAY_NS, CLK_MHZ)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       port_busy_i,
    input  logic       ext_ack_i,
    output logic       ext_req_o,
    output logic       ee_cs_o,
    output logic       ee_sk_o,
    output logic       ee_do_o,
    input  logic       ee_di_i
);
    ctrl_t ctrl;
    logic  req_wr, rel_wr, grant_now, granted, held, rdy, restart;

    assign req_wr  = wr_en &  wr_data[B_PREQ];
    assign rel_wr  = wr_en & ~wr_data[B_PREQ];
    assign restart = req_wr & granted;

    eeprom_ctrl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl_o  (ctrl)
    );

    eeprom_port_grant u_grant (
        .clk         (clk),
        .rst         (rst),
        .req_wr_i    (req_wr),
        .rel_wr_i    (rel_wr),
        .port_busy_i (port_busy_i),
        .grant_now_o (grant_now),
        .granted_o   (granted),
        .held_o      (held)
    );

    eeprom_ready_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .grant_now_i (grant_now),
        .restart_i   (restart),
        .release_i   (rel_wr),
        .rdy_o       (rdy)
    );

    eeprom_pin_gate u_gate (
        .granted_i (granted),
        .held_i    (held),
        .rdy_i     (rdy),
        .ctrl_i    (ctrl),
        .ext_ack_i (ext_ack_i),
        .ee_di_i   (ee_di_i),
        .ee_cs_o   (ee_cs_o),
        .ee_sk_o   (ee_sk_o),
        .ee_do_o   (ee_do_o),
        .ext_req_o (ext_req_o),
        .rd_data   (rd_data)
    );

    // R8: after a release write the pins and ready are all low
    assert_release_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        rel_wr |=> (!ee_cs_o && !ee_sk_o && !ee_do_o && !rd_data[B_RDY]));

    // R3: the grant edge shows ready immediately
    assert_grant_ready_R3: assert property (@(posedge clk) disable iff (rst)
        grant_now |=> rd_data[B_RDY]);
endmodule

// File: tb/eeprom_port_arbiter_tb.sv
module eeprom_port_arbiter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DLY        = 80;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       port_busy_i = 1'b0;
    logic       ext_ack_i = 1'b0;
    logic       ext_req_o, ee_cs_o, ee_sk_o, ee_do_o;
    logic       ee_di_i = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_port_arbiter u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .port_busy_i(port_busy_i), .ext_ack_i(ext_ack_i), .ext_req_o(ext_req_o),
        .ee_cs_o(ee_cs_o), .ee_sk_o(ee_sk_o), .ee_do_o(ee_do_o), .ee_di_i(ee_di_i)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [7:0] pins();
        return {5'd0, ee_cs_o, ee_sk_o, ee_do_o};
    endfunction

    task automatic t_reset;
        check("R1 rd_data low bits", {1'b0, rd_data[6:0]}, 8'h00);
        check("R1 pins", pins(), 8'h00);
        check("R1 ext_req_o", {7'd0, ext_req_o}, 8'h00);
    endtask

    task automatic t_busy_grant;
        port_busy_i = 1'b1;
        wr(8'h20);
        wait_neg(5);
        check("R2 no grant while busy, ready", {7'd0, rd_data[4]}, 8'h00);
        check("R2 request held bit5", {7'd0, rd_data[5]}, 8'h01);
        port_busy_i = 1'b0;
        @(negedge clk);
        check("R3 ready on grant edge", {7'd0, rd_data[4]}, 8'h01);
        wr(8'h00);
    endtask

    task automatic t_quick_grant;
        wr(8'h20);
        check("R3 ready not before grant edge", {7'd0, rd_data[4]}, 8'h00);
        @(negedge clk);
        check("R3 ready one edge after request", {7'd0, rd_data[4]}, 8'h01);
    endtask

    task automatic t_pins_and_delay;
        wr(8'h2E);
        check("R4 pins follow bits 3..1", pins(), 8'h07);
        check("R6 ready low after write", {7'd0, rd_data[4]}, 8'h00);
        wait_neg(DLY - 1);
        check("R6 ready still low one edge early", {7'd0, rd_data[4]}, 8'h00);
        @(negedge clk);
        check("R6 ready back after delay", {7'd0, rd_data[4]}, 8'h01);
        wr(8'h2A);
        check("R4 pins after second pattern", pins(), 8'h05);
        ee_di_i = 1'b1; #1;
        check("R4 bit0 reads data-in high", {7'd0, rd_data[0]}, 8'h01);
        ee_di_i = 1'b0; #1;
        check("R4 bit0 reads data-in low", {7'd0, rd_data[0]}, 8'h00);
        wait_neg(DLY);
    endtask

    task automatic t_restart;
        wr(8'h28);
        wait_neg(40);
        wr(8'h2C);
        wait_neg(DLY - 1);
        check("R7 restarted delay not yet done", {7'd0, rd_data[4]}, 8'h00);
        @(negedge clk);
        check("R7 ready after full restarted delay", {7'd0, rd_data[4]}, 8'h01);
    endtask

    task automatic t_release;
        wr(8'h0E);
        check("R8 pins low on release", pins(), 8'h00);
        check("R8 ready low on release", {7'd0, rd_data[4]}, 8'h00);
        check("R5 bits3..1 stored while ungranted", {5'd0, rd_data[3:1]}, 8'h07);
        ee_di_i = 1'b1; #1;
        check("R5 bit0 reads 0 when ungranted", {7'd0, rd_data[0]}, 8'h00);
        ee_di_i = 1'b0;
        port_busy_i = 1'b1;
        wr(8'h2E);
        wait_neg(3);
        check("R5 pins low while waiting on busy port", pins(), 8'h00);
        port_busy_i = 1'b0;
        @(negedge clk);
        check("R8 regrant after new request", {7'd0, rd_data[4]}, 8'h01);
        wr(8'h00);
    endtask

    task automatic t_ext_bits;
        wr(8'hD1);
        check("R9 ext_req_o follows bit6", {7'd0, ext_req_o}, 8'h01);
        check("R9 bits 7,4,0 ignore writes", {rd_data[7], 2'b00, rd_data[4], 3'b000, rd_data[0]}, 8'h00);
        check("R9 bit6 reads back", {7'd0, rd_data[6]}, 8'h01);
        ext_ack_i = 1'b1; #1;
        check("R9 bit7 reads ext_ack_i", {7'd0, rd_data[7]}, 8'h01);
        ext_ack_i = 1'b0;
        wr(8'h00);
        check("R9 bit6 clears", {7'd0, ext_req_o}, 8'h00);
    endtask

    initial begin
        wait_neg(3);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_busy_grant();
        t_quick_grant();
        t_pins_and_delay();
        t_restart();
        t_release();
        t_ext_bits();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule